// File: doc/BRIEF.md
# I2C Bus Condition Generator (START / STOP)

This block is the part of an I2C master that puts START and STOP conditions on the bus. It drives two open-drain lines, SCL and SDA. Each line has an output enable, and its data pin is tied low, so an asserted enable pulls the line low and a cleared enable lets the pull-up take it high. Software first writes a control byte that places the block in master-transmit standby for either a START or a STOP. In START standby SDA is released; in STOP standby SDA is pulled low. A later write to the data register launches the condition that was prepared.

The setup interval runs from releasing SCL to moving SDA. The hold interval runs from moving SDA to finishing the condition. Both intervals use the same length, counted in internal clock cycles. The length is taken from a table indexed by a clock-mode input and a generation-select input. It is sampled when the condition is launched. A finished START leaves SCL and SDA both pulled low and sets a bus-busy flag. A finished STOP leaves both lines released and clears that flag. Every finished condition gives a single-cycle done pulse.

Top module: `i2c_cond_gen`

## Requirements
- R1: After reset, scl_oe, sda_oe, bus_busy and cond_done are all 0, and scl_o and sda_o are 0 at all times.
- R2: The control byte is decoded as follows: bit 7 is master, bit 6 is transmit, bit 5 is busy, bit 4 is interrupt-pending, and bits 3:0 form a low field. A control write of 8'hE0 arms START standby: sda_oe is 0 from the next cycle, and scl_oe is unchanged.
- R3: A control write of 8'hC0 arms STOP standby: sda_oe is 1 from the next cycle.
- R4: A control write with master=1, transmit=1 and a low field of 4'hF (for example 8'hCF) arms nothing. Any control write that matches neither standby pattern is also ignored. The lines do not change, and a following data write launches nothing.
- R5: The interval length N is 20 cycles when clock_mode=0 and gen_sel=0, 52 when clock_mode=0 and gen_sel=1, 10 when clock_mode=1 and gen_sel=0, and 26 when clock_mode=1 and gen_sel=1. N is sampled in the cycle of the launching data write.
- R6: A launched START releases SCL in the launch cycle. Exactly N cycles later it pulls SDA low while SCL is still released. N cycles after that it pulls SCL low.
- R7: A launched STOP releases SCL in the launch cycle while SDA stays low. Exactly N cycles later it releases SDA. N cycles after that the condition ends with both lines released.
- R8: cond_done is high for exactly one cycle, in the cycle in which the last line change of a condition becomes visible. bus_busy becomes 1 at the end of a START, becomes 0 at the end of a STOP, and changes at no other time.
- R9: A data write while no standby is armed has no effect: no line moves and no cond_done is produced.
- R10: A control write made while a condition is running is ignored, and the running condition finishes with its own timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock that sets the interval counts |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control-byte write strobe |
| ctl_byte | input | 8 | Control byte (see R2) |
| dat_wr | input | 1 | Data-register write strobe; launches an armed condition |
| clock_mode | input | 1 | 0 = standard, 1 = high-speed interval table |
| gen_sel | input | 1 | Selects the short or the long interval |
| scl_o | output | 1 | SCL data, always 0 (open drain) |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_o | output | 1 | SDA data, always 0 (open drain) |
| sda_oe | output | 1 | 1 pulls SDA low |
| bus_busy | output | 1 | Set by a finished START, cleared by a finished STOP |
| cond_done | output | 1 | One-cycle pulse at the end of each condition |

## Verification
The embedded assertions check, on every cycle, the following invariants: the done pulse lasts a single cycle, bus_busy moves only together with it, SDA stays still and SCL stays released through the setup phase, the interval counter stays below its limit, an unarmed data write leaves the sequencer idle, and START arming releases SDA. Other behaviour needs the bench's scenarios. These scenarios cover the exact setup and hold spacing for each of the four table entries, the line levels at each step of START and STOP, and the refusal of mode-only control bytes and of stray data writes. They also cover a control write arriving in the middle of a condition.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

   typedef enum logic [2:0] {
      S_IDLE      = 3'd0,
      S_ARM_START = 3'd1,
      S_ARM_STOP  = 3'd2,
      S_SETUP     = 3'd3,
      S_HOLD      = 3'd4
   } seq_state_e;

   typedef struct packed {
      logic       master;
      logic       xmit;
      logic       busy;
      logic       pend;
      logic [3:0] low;
   } ctl_fields_t;

endpackage

// File: rtl/i2c_cond_decode.sv
module i2c_cond_decode
   import i2c_cond_pkg::*;
#(
   parameter int CTL_W = 8
) (
   input  logic             ctl_wr,
   input  logic [CTL_W-1:0] ctl_byte,
   output logic             want_start,
   output logic             want_stop
);
   if (CTL_W != $bits(ctl_fields_t)) begin : g_bad_width
      $error("i2c_cond_decode: CTL_W must match the control field layout");
   end

   ctl_fields_t f;
   logic        base_ok;

   assign f       = ctl_fields_t'(ctl_byte);
   // master transmit with no pending interrupt and a cleared low field
   assign base_ok = ctl_wr && f.master && f.xmit && !f.pend && (f.low == 4'h0);

   assign want_start = base_ok &&  f.busy;
   assign want_stop  = base_ok && !f.busy;
endmodule

// File: rtl/i2c_cond_timer.sv
module i2c_cond_timer #(
   parameter int CNT_W      = 6,
   parameter bit DOWN_COUNT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [CNT_W-1:0] limit,
   output logic             expire
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("i2c_cond_timer: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt;
   logic             running;
   logic             hit;

   if (DOWN_COUNT) begin : g_down
      assign hit = (cnt == '0);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
         end else if (restart) begin
            cnt     <= limit - CNT_W'(1);
            running <= 1'b1;
         end else if (running) begin
            if (hit) running <= 1'b0;
            else     cnt     <= cnt - CNT_W'(1);
         end
      end
   end else begin : g_up
      assign hit = (cnt == limit - CNT_W'(1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
         end else if (restart) begin
            cnt     <= '0;
            running <= 1'b1;
         end else if (running) begin
            if (hit) running <= 1'b0;
            else     cnt     <= cnt + CNT_W'(1);
         end
      end
   end

   assign expire = running && hit;

   // R5: the phase counter never walks past its interval
   p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (cnt < limit));
endmodule

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq
   import i2c_cond_pkg::*;
#(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             want_start,
   input  logic             want_stop,
   input  logic             dat_wr,
   input  logic [CNT_W-1:0] sel_limit,
   input  logic             expire,
   output logic             restart,
   output logic [CNT_W-1:0] limit,
   output logic             scl_oe,
   output logic             sda_oe,
   output logic             busy,
   output logic             done
);
   seq_state_e       state;
   logic             is_stop;
   logic [CNT_W-1:0] lim_q;
   logic             can_arm;
   logic             fire;

   assign can_arm = (state == S_IDLE) || (state == S_ARM_START) || (state == S_ARM_STOP);
   assign fire    = dat_wr && !want_start && !want_stop &&
                    ((state == S_ARM_START) || (state == S_ARM_STOP));
   assign restart = fire || ((state == S_SETUP) && expire);
   assign limit   = ((state == S_SETUP) || (state == S_HOLD)) ? lim_q : sel_limit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         is_stop <= 1'b0;
         lim_q   <= '0;
         scl_oe  <= 1'b0;
         sda_oe  <= 1'b0;
         busy    <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            S_IDLE, S_ARM_START, S_ARM_STOP: begin
               if (can_arm && want_start) begin
                  state  <= S_ARM_START;
                  sda_oe <= 1'b0;
               end else if (can_arm && want_stop) begin
                  state  <= S_ARM_STOP;
                  sda_oe <= 1'b1;
               end else if (fire) begin
                  state   <= S_SETUP;
                  is_stop <= (state == S_ARM_STOP);
                  lim_q   <= sel_limit;
                  scl_oe  <= 1'b0;
               end
            end
            S_SETUP: begin
               if (expire) begin
                  state  <= S_HOLD;
                  sda_oe <= !is_stop;
               end
            end
            S_HOLD: begin
               if (expire) begin
                  state  <= S_IDLE;
                  done   <= 1'b1;
                  busy   <= !is_stop;
                  scl_oe <= !is_stop;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   // R8: completion strobe lasts a single cycle
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R8: busy flag only moves at the end of a condition
   p_busy_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(busy) |-> done);
   // R6: SDA holds still across the setup phase
   p_sda_still_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_SETUP && $past(state) == S_SETUP) |-> $stable(sda_oe));
   // R6: SCL stays released while the setup interval runs
   p_scl_free_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_SETUP) |-> !scl_oe);
   // R9: stray data write while idle does not start anything
   p_idle_dat_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_IDLE && dat_wr && !want_start && !want_stop) |=> (state == S_IDLE));
   // R2: START arming releases SDA on the next cycle
   p_start_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (can_arm && want_start) |=> !sda_oe);
endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen #(
   parameter int STD_SHORT  = 20,
   parameter int STD_LONG   = 52,
   parameter int HS_SHORT   = 10,
   parameter int HS_LONG    = 26,
   parameter bit DOWN_COUNT = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_wr,
   input  logic [7:0] ctl_byte,
   input  logic       dat_wr,
   input  logic       clock_mode,
   input  logic       gen_sel,
   output logic       scl_o,
   output logic       scl_oe,
   output logic       sda_o,
   output logic       sda_oe,
   output logic       bus_busy,
   output logic       cond_done
);
   localparam int MAX_A  = (STD_SHORT > STD_LONG) ? STD_SHORT : STD_LONG;
   localparam int MAX_B  = (HS_SHORT > HS_LONG) ? HS_SHORT : HS_LONG;
   localparam int MAX_N  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int CNT_W  = (MAX_N < 3) ? 2 : $clog2(MAX_N + 1);

   if (STD_SHORT < 1 || STD_LONG < 1 || HS_SHORT < 1 || HS_LONG < 1) begin : g_bad_counts
      $error("i2c_cond_gen: every interval count must be at least 1");
   end

   logic             want_start;
   logic             want_stop;
   logic             restart;
   logic             expire;
   logic [CNT_W-1:0] sel_limit;
   logic [CNT_W-1:0] limit;

   always_comb begin
      unique case ({clock_mode, gen_sel})
         2'b00:   sel_limit = CNT_W'(STD_SHORT);
         2'b01:   sel_limit = CNT_W'(STD_LONG);
         2'b10:   sel_limit = CNT_W'(HS_SHORT);
         default: sel_limit = CNT_W'(HS_LONG);
      endcase
   end

   i2c_cond_decode #(.CTL_W(8)) u_decode (
      .ctl_wr     (ctl_wr),
      .ctl_byte   (ctl_byte),
      .want_start (want_start),
      .want_stop  (want_stop)
   );

   i2c_cond_timer #(.CNT_W(CNT_W), .DOWN_COUNT(DOWN_COUNT)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .limit   (limit),
      .expire  (expire)
   );

   i2c_cond_seq #(.CNT_W(CNT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .want_start (want_start),
      .want_stop  (want_stop),
      .dat_wr     (dat_wr),
      .sel_limit  (sel_limit),
      .expire     (expire),
      .restart    (restart),
      .limit      (limit),
      .scl_oe     (scl_oe),
      .sda_oe     (sda_oe),
      .busy       (bus_busy),
      .done       (cond_done)
   );

   assign scl_o = 1'b0;
   assign sda_o = 1'b0;
endmodule

// File: tb/sim_i2c_cond_gen.sv
module sim_i2c_cond_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_wr = 1'b0;
   logic [7:0] ctl_byte = 8'h00;
   logic       dat_wr = 1'b0;
   logic       clock_mode = 1'b0;
   logic       gen_sel = 1'b0;
   logic       scl_o, scl_oe, sda_o, sda_oe, bus_busy, cond_done;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   i2c_cond_gen u0 (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_byte(ctl_byte),
      .dat_wr(dat_wr), .clock_mode(clock_mode), .gen_sel(gen_sel),
      .scl_o(scl_o), .scl_oe(scl_oe), .sda_o(sda_o), .sda_oe(sda_oe),
      .bus_busy(bus_busy), .cond_done(cond_done)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // scoreboard: expected interval length and kind for each launched condition
   int exp_n[$];
   bit exp_stop[$];

   bit active = 1'b0;
   bit seen_sda;
   bit prev_sda;
   int cyc = 0;
   int t_fire, t_sda;

   always @(posedge clk) begin
      #2;
      cyc++;
      if (rst_n) begin
         if (!active && dat_wr && exp_n.size() > 0) begin
            active   = 1'b1;
            t_fire   = cyc;
            seen_sda = 1'b0;
            prev_sda = sda_oe;
         end else if (active) begin
            if (!seen_sda && sda_oe != prev_sda) begin
               seen_sda = 1'b1;
               t_sda    = cyc;
               check(t_sda - t_fire == exp_n[0], exp_stop[0] ? "R7 setup" : "R6 setup",
                     t_sda - t_fire, exp_n[0]);
               check(scl_oe == 1'b0, "R6/R7 scl released at data move", scl_oe, 0);
               check(sda_oe == !exp_stop[0], "R6/R7 sda level", sda_oe, !exp_stop[0]);
            end
            if (cond_done) begin
               check(seen_sda, "R6/R7 sda moved before done", seen_sda, 1);
               check(cyc - t_sda == exp_n[0], "R5 hold length", cyc - t_sda, exp_n[0]);
               check(bus_busy == !exp_stop[0], "R8 busy", bus_busy, !exp_stop[0]);
               check(scl_oe == !exp_stop[0], "R6/R7 final scl", scl_oe, !exp_stop[0]);
               void'(exp_n.pop_front());
               void'(exp_stop.pop_front());
               active = 1'b0;
            end
         end else if (cond_done) begin
            check(1'b0, "R9 unexpected done", 1, 0);
         end
      end
   end

   task automatic ctl_write(input logic [7:0] b);
      @(negedge clk); ctl_byte = b; ctl_wr = 1'b1;
      @(negedge clk); ctl_wr = 1'b0;
   endtask

   task automatic launch(input bit stop, input bit hs, input bit sel, input int n);
      @(negedge clk);
      clock_mode = hs; gen_sel = sel;
      exp_n.push_back(n); exp_stop.push_back(stop);
      dat_wr = 1'b1;
      @(negedge clk); dat_wr = 1'b0;
   endtask

   task automatic wait_idle();
      while (active || exp_n.size() > 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      bit keep_sda;
      repeat (3) @(negedge clk);
      // R1 reset state
      check({scl_oe, sda_oe, bus_busy, cond_done} == 4'b0, "R1 reset outputs",
            {scl_oe, sda_oe, bus_busy, cond_done}, 0);
      check({scl_o, sda_o} == 2'b0, "R1 data pins low", {scl_o, sda_o}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R9 data write with nothing armed
      @(negedge clk); dat_wr = 1'b1; @(negedge clk); dat_wr = 1'b0;
      repeat (80) @(negedge clk);
      check({scl_oe, sda_oe} == 2'b00, "R9 lines unchanged", {scl_oe, sda_oe}, 0);

      // R2 START standby, R5 standard short, R6 sequence
      ctl_write(8'hE0);
      check(sda_oe == 1'b0 && scl_oe == 1'b0, "R2 start standby", sda_oe, 0);
      launch(1'b0, 1'b0, 1'b0, 20);
      // R10 stop pattern in mid condition must be ignored
      repeat (5) @(negedge clk);
      ctl_write(8'hC0);
      wait_idle();
      check(bus_busy == 1'b1, "R8 busy after start", bus_busy, 1);

      // R3 STOP standby, R5 high-speed long, R7 sequence
      ctl_write(8'hC0);
      check(sda_oe == 1'b1, "R3 stop standby drives sda", sda_oe, 1);
      launch(1'b1, 1'b1, 1'b1, 26);
      wait_idle();
      check(bus_busy == 1'b0 && sda_oe == 1'b0, "R7 bus released", {bus_busy, sda_oe}, 0);

      // R4 mode-only write arms nothing
      ctl_write(8'hE0);
      launch(1'b0, 1'b1, 1'b0, 10);
      wait_idle();
      keep_sda = sda_oe;
      ctl_write(8'hCF);
      check(sda_oe == keep_sda, "R4 mode write leaves sda", sda_oe, keep_sda);
      ctl_write(8'hF0);
      check(sda_oe == keep_sda, "R4 pending-bit write ignored", sda_oe, keep_sda);
      @(negedge clk); dat_wr = 1'b1; @(negedge clk); dat_wr = 1'b0;
      repeat (120) @(negedge clk);
      check(scl_oe == 1'b1 && sda_oe == keep_sda, "R4 no launch after mode write",
            {scl_oe, sda_oe}, {1'b1, keep_sda});

      // R5 standard long STOP
      ctl_write(8'hC0);
      launch(1'b1, 1'b0, 1'b1, 52);
      wait_idle();

      // R5 high-speed short START after STOP
      ctl_write(8'hE0);
      launch(1'b0, 1'b1, 1'b0, 10);
      wait_idle();
      check(bus_busy == 1'b1, "R8 busy set again", bus_busy, 1);

      finish_run();
   end
endmodule